// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width-modulated output whose duty can be set in steps of a quarter timer tick. A free-running 2-bit phase counter advances on every clock and carries into an 8-bit tick counter, so together they form a 10-bit time base. An 8-bit period register sets where the tick counter wraps. At each wrap (the period boundary) the tick counter clears, the output is set, a one-cycle strobe is raised, and the 10-bit duty value held in the write-side registers is copied into a slave register that the output comparator uses for the whole following cycle. The output falls when the time base reaches the slave duty value.

Software-side configuration goes through a simple synchronous write port with a 2-bit address. The control register carries the run enable, the two low duty bits and the output-drive bit; the period and the upper 8 duty bits each have their own address. Clearing the run enable stops the time base and forces the output latch low. The output-enable port tells the pad logic whether the pin should be driven.

Top module: `pwm_gen`

## Requirements
- R1: While enabled, the time base advances one count per clock and the tick counter wraps after it equals the period register P while the phase bits are all ones, so period strobes are spaced exactly 4*(P+1) clocks apart.
- R2: `period_strobe` is high for exactly one clock at each period boundary, in the cycle where the time base reads zero.
- R3: The active duty D is {upper byte, two low bits}; in each cycle after a boundary, `pwm_out` is high for exactly D clocks starting with the strobe cycle, then low for the rest of the period.
- R4: A duty value of 0 keeps `pwm_out` low for the entire period.
- R5: A duty value of 4*(P+1) or more keeps `pwm_out` high for the entire period.
- R6: Duty writes made during a period do not change that period's pulse; the new value is taken at the next boundary.
- R7: After the run enable is set, the time base starts from zero and `pwm_out` stays low until the first boundary, which loads the duty value and starts the first pulse.
- R8: Writing the control register with the enable bit clear forces `pwm_out` low by the second clock after the write and stops all strobes while disabled.
- R9: `pwm_oe` equals the drive bit of the last control write, one clock after that write.
- R10: After reset `pwm_out`, `pwm_oe` and `period_strobe` are low and the block is disabled.
- R11: Register addresses: 0 is control (bit 0 run enable, bits 2:1 low duty bits, bit 3 drive), 1 is the period, 2 is the upper duty byte; address 3 is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | TMR_W (8) | Write data |
| pwm_out | output | 1 | Registered PWM output latch |
| pwm_oe | output | 1 | Pin drive enable (drive bit of control) |
| period_strobe | output | 1 | One-cycle pulse at each period boundary |

## Verification
On every cycle the checker confirms that the strobe is single-cycle and coincides with a zero time base, that the output is only high while the time base is below the active duty, that the active duty changes only at a boundary, and that disabling and the drive bit reach the ports with the stated latency. The exact period length, the measured high time for ordinary, zero and saturated duty values, the quiet first period after enabling, and the deferral of a mid-period duty write are only visible across whole periods, so the bench's directed scenarios measure those by counting clocks between strobes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Register select codes on the write port.
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // Control register layout: run enable at bit 0, low duty bits above it,
  // drive bit directly above the low duty bits.
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_LO_LSB  = 1;

  function automatic int ctrl_drive_bit(input int sub_w);
    return sub_w + 1;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] period_q,
  output logic [TMR_W-1:0] duty_hi_q,
  output logic [SUB_W-1:0] duty_lo_q,
  output logic             run_q,
  output logic             drive_q
);

  localparam int DRIVE_BIT = ctrl_drive_bit(SUB_W);
  localparam int LO_MSB    = CTRL_LO_LSB + SUB_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      run_q     <= 1'b0;
      drive_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          run_q     <= wr_data[CTRL_RUN_BIT];
          duty_lo_q <= wr_data[LO_MSB:CTRL_LO_LSB];
          drive_q   <= wr_data[DRIVE_BIT];
        end
        REG_PERIOD: period_q  <= wr_data;
        REG_DUTY:   duty_hi_q <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMR_W-1:0] period,
  output logic [DW-1:0]    time_base,
  output logic             period_hit
);

  logic [SUB_W-1:0] phase;
  logic [TMR_W-1:0] tick;
  logic             phase_wrap;

  assign phase_wrap = &phase;
  assign period_hit = run && phase_wrap && (tick == period);
  assign time_base  = {tick, phase};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
      tick  <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase_wrap) begin
        if (tick == period) tick <= '0;
        else                tick <= tick + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          period_hit,
  input  logic [DW-1:0] time_base,
  input  logic [DW-1:0] duty_next,
  output logic          pwm_q,
  output logic          strobe_q,
  output logic [DW-1:0] duty_active
);

  logic [DW-1:0] base_next;

  // Value the time base will hold after this edge.
  assign base_next = period_hit ? '0 : time_base + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q       <= 1'b0;
      strobe_q    <= 1'b0;
      duty_active <= '0;
    end else begin
      strobe_q <= period_hit;
      if (period_hit) duty_active <= duty_next;
      if (!run)
        pwm_q <= 1'b0;
      else if (period_hit)
        pwm_q <= (duty_next != '0);
      else if (base_next == duty_active)
        pwm_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             pwm_oe,
  output logic             period_strobe
);

  localparam int DW = TMR_W + SUB_W;

  logic [TMR_W-1:0] period;
  logic [TMR_W-1:0] duty_hi;
  logic [SUB_W-1:0] duty_lo;
  logic             run;
  logic [DW-1:0]    time_base;
  logic             period_hit;
  logic [DW-1:0]    duty_active;

  pwm_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .period_q  (period),
    .duty_hi_q (duty_hi),
    .duty_lo_q (duty_lo),
    .run_q     (run),
    .drive_q   (pwm_oe)
  );

  pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .period     (period),
    .time_base  (time_base),
    .period_hit (period_hit)
  );

  pwm_outstage #(.DW(DW)) u_out (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .period_hit  (period_hit),
    .time_base   (time_base),
    .duty_next   ({duty_hi, duty_lo}),
    .pwm_q       (pwm_out),
    .strobe_q    (period_strobe),
    .duty_active (duty_active)
  );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DW   = TMR_W + SUB_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [TMR_W-1:0] wr_data,
  input logic             pwm_out,
  input logic             pwm_oe,
  input logic             period_strobe,
  input logic [DW-1:0]    time_base,
  input logic [DW-1:0]    duty_active
);

  localparam int DRIVE_BIT = pwm_pkg::ctrl_drive_bit(SUB_W);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == pwm_pkg::REG_CTRL);

  // R2 and R1: boundary strobe is single and lands on a zero time base
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    period_strobe |=> !period_strobe);
  a_r1_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
    period_strobe |-> (time_base == '0));

  // R3: output high only while below the active duty
  a_r3_high_below_duty: assert property (@(posedge clk) disable iff (rst)
    pwm_out |-> (time_base < duty_active));
  a_r3_set_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (period_strobe && duty_active != '0) |-> pwm_out);

  // R4: zero duty keeps the boundary cycle low
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (period_strobe && duty_active == '0) |-> !pwm_out);

  // R6: active duty changes only at a boundary
  a_r6_slave_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_active) |-> period_strobe);

  // R8: clearing run forces the output low and silences strobes
  a_r8_stop_low: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_data[0]) |-> ##2 (!pwm_out && !period_strobe));

  // R9: drive bit reaches the output enable one clock later
  a_r9_drive_follow: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (pwm_oe == $past(wr_data[DRIVE_BIT])));

endmodule

bind pwm_gen pwm_gen_chk #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .pwm_out       (pwm_out),
  .pwm_oe        (pwm_oe),
  .period_strobe (period_strobe),
  .time_base     (time_base),
  .duty_active   (duty_active)
);

// File: tb/test_pwm_gen.sv
module test_pwm_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, pwm_oe, period_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_DUTY = 2'd2;

  always #5 clk = ~clk;

  pwm_gen i_pwm_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .period_strobe(period_strobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // advance to the next negedge where the strobe is high
  task automatic sync_strobe();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_strobe && n < 5000);
  endtask

  // called at a negedge with the strobe high; counts one whole period
  task automatic measure(output int len, output int high);
    len = 0; high = 0;
    do begin
      if (pwm_out) high++;
      len++;
      @(negedge clk);
    end while (!period_strobe && len < 5000);
  endtask

  task automatic set_duty(input int p, input int d);
    wr(A_PER, 8'(p));
    wr(A_DUTY, 8'(d >> 2));
    wr(A_CTRL, 8'(8'h09 | ((d & 3) << 1)));
  endtask

  task automatic t_reset();
    chk("R10 pwm_out after reset", int'(pwm_out), 0);
    chk("R10 pwm_oe after reset", int'(pwm_oe), 0);
    chk("R10 strobe after reset", int'(period_strobe), 0);
  endtask

  task automatic t_start();
    int len, high, pre = 0, n = 0;
    wr(A_PER, 8'd4);
    wr(A_DUTY, 8'd2);
    wr(A_CTRL, 8'h0F);          // R11: run=1, low bits=3, drive=1
    chk("R9 drive bit on pwm_oe", int'(pwm_oe), 1);
    while (!period_strobe && n < 5000) begin
      if (pwm_out) pre++;
      n++;
      @(negedge clk);
    end
    chk("R7 low before first boundary", pre, 0);
    measure(len, high);
    chk("R1 period length P=4", len, 20);
    chk("R7 first period uses loaded duty 11", high, 11);
  endtask

  task automatic t_strobe_width();
    sync_strobe();
    @(negedge clk);
    chk("R2 strobe one cycle wide", int'(period_strobe), 0);
  endtask

  task automatic t_duty_values();
    int len, high;
    set_duty(4, 8);  sync_strobe(); measure(len, high);
    chk("R3 duty 8 high time", high, 8);
    set_duty(4, 11); sync_strobe(); measure(len, high);
    chk("R3 duty 11 uses low bits", high, 11);
    set_duty(4, 19); sync_strobe(); measure(len, high);
    chk("R3 duty 19 one below full", high, 19);
    set_duty(4, 0);  sync_strobe(); measure(len, high);
    chk("R4 zero duty stays low", high, 0);
    set_duty(4, 20); sync_strobe(); measure(len, high);
    chk("R5 duty equal to full period", high, 20);
    set_duty(4, 40); sync_strobe(); measure(len, high);
    chk("R5 duty above full period", high, 20);
  endtask

  task automatic t_periods();
    int len, high;
    set_duty(0, 2); sync_strobe(); measure(len, high);
    chk("R1 period length P=0", len, 4);
    chk("R3 duty 2 in short period", high, 2);
    set_duty(9, 13); sync_strobe(); measure(len, high);
    chk("R1 period length P=9", len, 40);
    chk("R3 duty 13 in P=9", high, 13);
  endtask

  task automatic t_buffer();
    int len, high;
    set_duty(4, 8);
    sync_strobe();
    fork
      measure(len, high);
      begin
        repeat (5) @(negedge clk);
        wr(A_DUTY, 8'd1);       // new duty 4, below the current base
      end
    join
    chk("R6 mid-period write leaves current pulse", high, 8);
    measure(len, high);
    chk("R6 new duty from next boundary", high, 4);
  endtask

  task automatic t_stop();
    int hi = 0, st = 0;
    set_duty(4, 40);
    sync_strobe();
    @(negedge clk);
    chk("R5 output high before stop", int'(pwm_out), 1);
    wr(A_CTRL, 8'h08);          // run=0, drive=1
    @(negedge clk);
    chk("R8 output low after stop", int'(pwm_out), 0);
    for (int i = 0; i < 50; i++) begin
      if (pwm_out) hi++;
      if (period_strobe) st++;
      @(negedge clk);
    end
    chk("R8 output stays low while stopped", hi, 0);
    chk("R8 no strobes while stopped", st, 0);
    chk("R9 drive kept while stopped", int'(pwm_oe), 1);
    wr(A_CTRL, 8'h01);
    chk("R9 drive bit cleared", int'(pwm_oe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_strobe_width();
    t_duty_values();
    t_periods();
    t_buffer();
    t_stop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule